// File: doc/BRIEF.md
# TDM Audio Frame Transmitter

This block is a master-mode serial audio transmitter. It divides the system clock into a bit clock, drives a frame sync, and shifts audio words out on a serial data line. Each word occupies one time slot, and a frame holds several slots. The frame length, sync pulse shape and slot geometry are set by run-time inputs rather than fixed to a stereo layout. The block can therefore serve two-channel links, multi-channel links, and links with unusual spacing.

Samples arrive on a valid/ready stream. The transmitter asks for one sample at the first bit of every active slot. It keeps a sticky underflow flag that records a slot that had to go out empty. The configuration is captured only when a frame begins, so a frame in flight keeps one consistent layout. The enable input is also sampled only at a frame boundary.

Top module: `tdm_tx`

## Requirements
- R1: While reset is held, sclk, fsync, sdata, busy, underflow and s_ready are all 0.
- R2: One bit lasts 2*HALF_DIV system clocks. With cfg_clk_pol=0, sclk is low in the first half of each bit and high in the second half, so data changes on the falling edge. With cfg_clk_pol=1 both halves are inverted. When idle, sclk rests at the level given by cfg_clk_pol.
- R3: A frame is cfg_frame_len_m1+1 bits long (8 to 1024). Frames follow one another without a gap while tx_enable is 1. busy is 1 for exactly the bits of each frame.
- R4: Without early sync, fsync is active on bits 0 to cfg_sync_width_m1 of the frame. Active means 1, or 0 when cfg_sync_active_low=1. fsync rests at the inactive level when idle.
- R5: With cfg_sync_early=1, fsync is active on the last bit of a frame and on bits 0 to cfg_sync_width_m1-1 of the frame. A frame started from idle has no pulse before its bit 0.
- R6: The frame is divided into cfg_slot_count_m1+1 slots. Slot size code 1 gives 16 bits and code 3 gives 32 bits. Codes 0 and 2 make the slot size equal to the data size. Bits after the last slot are 0.
- R7: Inside a slot, the data bits occupy positions cfg_slot_offset to cfg_slot_offset+cfg_data_size_m1, cut off at the slot end. All other positions carry 0.
- R8: With cfg_lsb_first=0, the word's bit cfg_data_size_m1 goes out first. With cfg_lsb_first=1, bit 0 goes out first.
- R9: A 1 in bit i of cfg_slot_mask makes slot i inactive. An inactive slot carries all zeros and takes no sample.
- R10: s_ready is high for one system clock, at the boundary that begins each active slot. A sample is taken in that cycle when s_valid is 1.
- R11: If an active slot starts while s_valid is 0, underflow is set and that slot carries zeros. underflow stays set until a frame starts from idle, which clears it.
- R12: A configuration change made during a frame has no effect until the next frame starts.
- R13: When tx_enable drops during a frame, that frame completes in full and the block then goes idle with sdata at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Run request, sampled at frame boundaries |
| cfg_frame_len_m1 | input | 10 | Frame length in bits minus one |
| cfg_sync_width_m1 | input | 8 | Frame sync width in bits minus one |
| cfg_sync_active_low | input | 1 | 1: frame sync is active low |
| cfg_sync_early | input | 1 | 1: frame sync starts one bit before the frame |
| cfg_slot_count_m1 | input | 5 | Number of slots minus one |
| cfg_slot_size | input | 2 | Slot size code (0/2 data size, 1 sixteen, 3 thirty-two) |
| cfg_slot_offset | input | 5 | Position of the first data bit in a slot |
| cfg_data_size_m1 | input | 5 | Data word size minus one (7 to 31) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_clk_pol | input | 1 | Bit clock polarity |
| cfg_slot_mask | input | 32 | Per-slot inactive mask (1 = inactive) |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample, right-aligned |
| s_ready | output | 1 | Sample accepted this cycle when s_valid |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| busy | output | 1 | A frame is in progress |
| underflow | output | 1 | Sticky missing-sample flag |

## Verification
The bench targets the points where slot geometry and frame timing interact. It runs the shortest frame of 8 bits, a frame with spare bits after the last slot, and a data field that is cut off at the slot end. In each of these, an off-by-one in the slot counter would place the data bits one position late or let them spill into the next slot. It also tests early sync with the pulse wrapping across the frame boundary; a design that got this wrong would put the pulse at bit 0 or make it one bit too long. It tests masked slots: a design that consumed samples in inactive slots would drain the input stream faster, which the bench catches both cycle by cycle and through the sample count. Finally, it changes the configuration in the middle of a frame and drops tx_enable in the middle of a frame. A design that applied either change at once would alter the current frame's length, cut the frame short, or leave busy high for the wrong number of cycles.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int LEN_W     = 10;
  localparam int SYNCW_W   = 8;
  localparam int SLOTS_W   = 5;
  localparam int MAX_SLOTS = 1 << SLOTS_W;
  localparam int SIZE_W    = 5;
  localparam int OFF_W     = 5;
  localparam int WORD_W    = 1 << SIZE_W;
  localparam int SB_W      = SIZE_W + 2;

  // fields the serializer needs for the bit being sent
  typedef struct packed {
    logic [LEN_W-1:0]   len_m1;
    logic [SYNCW_W-1:0] sync_m1;
    logic               sync_low;
    logic               early;
    logic [OFF_W-1:0]   offset;
    logic [SIZE_W-1:0]  dsz_m1;
    logic               lsb_first;
    logic               clk_pol;
  } tdm_fmt_t;

  typedef struct packed {
    tdm_fmt_t               fmt;
    logic [SLOTS_W-1:0]     slots_m1;
    logic [1:0]             slot_code;
    logic [MAX_SLOTS-1:0]   mask;
  } tdm_cfg_t;

  typedef struct packed {
    logic             run;
    logic [LEN_W-1:0] bit_pos;
    logic [LEN_W-1:0] slot_idx;
    logic [SB_W-1:0]  slot_pos;
    tdm_cfg_t         cfg;
  } tdm_pos_t;

  function automatic logic [SB_W-1:0] slot_bits(input logic [1:0] code,
                                                input logic [SIZE_W-1:0] dsz_m1);
    case (code)
      2'd1:    slot_bits = SB_W'(16);
      2'd3:    slot_bits = SB_W'(32);
      default: slot_bits = SB_W'(dsz_m1) + SB_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bit_ev,
  output logic mid_ev
);
  localparam int PER  = 2 * HALF_DIV;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;

  logic [PH_W-1:0] ph_q;

  assign bit_ev = (ph_q == PH_W'(PER - 1));
  assign mid_ev = (ph_q == PH_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)         ph_q <= '0;
    else if (bit_ev) ph_q <= '0;
    else             ph_q <= ph_q + PH_W'(1);
  end
endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
  import tdm_tx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_ev,
  input  logic                   enable,
  input  tdm_cfg_t               cfg_in,
  input  logic                   s_valid,
  output logic                   nx_run,
  output logic [LEN_W-1:0]       nx_bit_pos,
  output logic [SB_W-1:0]        nx_slot_pos,
  output tdm_fmt_t               nx_fmt,
  output logic                   take,
  output logic                   s_ready,
  output logic                   busy,
  output logic                   underflow
);
  tdm_pos_t        cur_q, nx;
  logic [SB_W-1:0] ssz_cur;
  logic            frame_end, start_idle, need;
  logic            uf_q;

  // next bit position, and config capture at frame start
  always_comb begin
    ssz_cur    = slot_bits(cur_q.cfg.slot_code, cur_q.cfg.fmt.dsz_m1);
    frame_end  = (cur_q.bit_pos == cur_q.cfg.fmt.len_m1);
    nx         = cur_q;
    start_idle = 1'b0;
    if (cur_q.run && !frame_end) begin
      nx.bit_pos = cur_q.bit_pos + LEN_W'(1);
      if (cur_q.slot_pos == ssz_cur - SB_W'(1)) begin
        nx.slot_pos = '0;
        nx.slot_idx = cur_q.slot_idx + LEN_W'(1);
      end else begin
        nx.slot_pos = cur_q.slot_pos + SB_W'(1);
      end
    end else if (enable) begin
      nx.run      = 1'b1;
      nx.cfg      = cfg_in;
      nx.bit_pos  = '0;
      nx.slot_idx = '0;
      nx.slot_pos = '0;
      start_idle  = !cur_q.run;
    end else begin
      nx.run = 1'b0;
    end
  end

  always_comb begin
    need = nx.run && (nx.slot_pos == '0)
        && (nx.slot_idx <= LEN_W'(nx.cfg.slots_m1))
        && !nx.cfg.mask[nx.slot_idx[SLOTS_W-1:0]];
  end

  assign s_ready     = bit_ev && need;
  assign take        = need && s_valid;
  assign nx_run      = nx.run;
  assign nx_bit_pos  = nx.bit_pos;
  assign nx_slot_pos = nx.slot_pos;
  assign nx_fmt      = nx.cfg.fmt;
  assign busy        = cur_q.run;
  assign underflow   = uf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      uf_q  <= 1'b0;
    end else if (bit_ev) begin
      cur_q <= nx;
      if (need && !s_valid) uf_q <= 1'b1;
      else if (start_idle)  uf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_ev,
  input  logic              mid_ev,
  input  logic              nx_run,
  input  logic [LEN_W-1:0]  nx_bit_pos,
  input  logic [SB_W-1:0]   nx_slot_pos,
  input  tdm_fmt_t          nx_fmt,
  input  logic              take,
  input  logic [WORD_W-1:0] s_data,
  input  logic              idle_pol,
  input  logic              idle_sync_low,
  output logic              sclk,
  output logic              fsync,
  output logic              sdata
);
  logic [WORD_W-1:0] word_q, word_nx;
  logic [SB_W-1:0]   k_full;
  logic [SIZE_W-1:0] k, idx;
  logic              in_field, sync_act;
  logic              run_q, pol_q, sclk_q, fsync_q, sdata_q;

  always_comb begin
    word_nx  = (nx_slot_pos == '0) ? (take ? s_data : '0) : word_q;
    k_full   = nx_slot_pos - SB_W'(nx_fmt.offset);
    k        = k_full[SIZE_W-1:0];
    in_field = nx_run && (nx_slot_pos >= SB_W'(nx_fmt.offset))
            && (k_full <= SB_W'(nx_fmt.dsz_m1));
    idx      = nx_fmt.lsb_first ? k : (nx_fmt.dsz_m1 - k);
    if (nx_fmt.early)
      sync_act = (nx_bit_pos == nx_fmt.len_m1) || (nx_bit_pos < LEN_W'(nx_fmt.sync_m1));
    else
      sync_act = (nx_bit_pos <= LEN_W'(nx_fmt.sync_m1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      run_q   <= 1'b0;
      pol_q   <= 1'b0;
      sclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      sdata_q <= 1'b0;
    end else if (bit_ev) begin
      word_q  <= word_nx;
      run_q   <= nx_run;
      pol_q   <= nx_fmt.clk_pol;
      sclk_q  <= nx_run ? nx_fmt.clk_pol : idle_pol;
      fsync_q <= nx_run ? (sync_act ^ nx_fmt.sync_low) : idle_sync_low;
      sdata_q <= in_field & word_nx[idx];
    end else if (mid_ev && run_q) begin
      sclk_q  <= ~pol_q;
    end
  end

  assign sclk  = sclk_q;
  assign fsync = fsync_q;
  assign sdata = sdata_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_enable,
  input  logic [LEN_W-1:0]     cfg_frame_len_m1,
  input  logic [SYNCW_W-1:0]   cfg_sync_width_m1,
  input  logic                 cfg_sync_active_low,
  input  logic                 cfg_sync_early,
  input  logic [SLOTS_W-1:0]   cfg_slot_count_m1,
  input  logic [1:0]           cfg_slot_size,
  input  logic [OFF_W-1:0]     cfg_slot_offset,
  input  logic [SIZE_W-1:0]    cfg_data_size_m1,
  input  logic                 cfg_lsb_first,
  input  logic                 cfg_clk_pol,
  input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
  input  logic                 s_valid,
  input  logic [WORD_W-1:0]    s_data,
  output logic                 s_ready,
  output logic                 sclk,
  output logic                 fsync,
  output logic                 sdata,
  output logic                 busy,
  output logic                 underflow
);
  tdm_cfg_t         cfg_live;
  tdm_fmt_t         nx_fmt;
  logic             bit_ev, mid_ev, nx_run, take;
  logic [LEN_W-1:0] nx_bit_pos;
  logic [SB_W-1:0]  nx_slot_pos;

  always_comb begin
    cfg_live.fmt.len_m1    = cfg_frame_len_m1;
    cfg_live.fmt.sync_m1   = cfg_sync_width_m1;
    cfg_live.fmt.sync_low  = cfg_sync_active_low;
    cfg_live.fmt.early     = cfg_sync_early;
    cfg_live.fmt.offset    = cfg_slot_offset;
    cfg_live.fmt.dsz_m1    = cfg_data_size_m1;
    cfg_live.fmt.lsb_first = cfg_lsb_first;
    cfg_live.fmt.clk_pol   = cfg_clk_pol;
    cfg_live.slots_m1      = cfg_slot_count_m1;
    cfg_live.slot_code     = cfg_slot_size;
    cfg_live.mask          = cfg_slot_mask;
  end

  tdm_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk(clk), .rst(rst), .bit_ev(bit_ev), .mid_ev(mid_ev)
  );

  tdm_frame_seq u_seq (
    .clk(clk), .rst(rst), .bit_ev(bit_ev), .enable(tx_enable), .cfg_in(cfg_live),
    .s_valid(s_valid), .nx_run(nx_run), .nx_bit_pos(nx_bit_pos),
    .nx_slot_pos(nx_slot_pos), .nx_fmt(nx_fmt), .take(take), .s_ready(s_ready),
    .busy(busy), .underflow(underflow)
  );

  tdm_serializer u_ser (
    .clk(clk), .rst(rst), .bit_ev(bit_ev), .mid_ev(mid_ev), .nx_run(nx_run),
    .nx_bit_pos(nx_bit_pos), .nx_slot_pos(nx_slot_pos), .nx_fmt(nx_fmt),
    .take(take), .s_data(s_data), .idle_pol(cfg_clk_pol),
    .idle_sync_low(cfg_sync_active_low), .sclk(sclk), .fsync(fsync), .sdata(sdata)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic busy,
  input logic underflow,
  input logic sdata
);
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> busy);

  // R11
  uf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $past(s_ready && !s_valid));

  // R11
  uf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(underflow)) |-> underflow);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sdata);
endmodule

bind tdm_tx tdm_tx_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .busy(busy), .underflow(underflow), .sdata(sdata)
);

// File: tb/tdm_tx_tb.sv
`timescale 1ns/1ps
module tdm_tx_tb;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [9:0]  c_len_m1;
  logic [7:0]  c_sw_m1;
  logic        c_low, c_early, c_lsb, c_pol;
  logic [4:0]  c_slots_m1, c_off, c_dsz_m1;
  logic [1:0]  c_code;
  logic [31:0] c_mask;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, sclk, fsync, sdata, busy, underflow;

  always #10 clk = ~clk;

  tdm_tx #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .tx_enable(en), .cfg_frame_len_m1(c_len_m1),
    .cfg_sync_width_m1(c_sw_m1), .cfg_sync_active_low(c_low), .cfg_sync_early(c_early),
    .cfg_slot_count_m1(c_slots_m1), .cfg_slot_size(c_code), .cfg_slot_offset(c_off),
    .cfg_data_size_m1(c_dsz_m1), .cfg_lsb_first(c_lsb), .cfg_clk_pol(c_pol),
    .cfg_slot_mask(c_mask), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sclk(sclk), .fsync(fsync), .sdata(sdata), .busy(busy), .underflow(underflow)
  );

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";
  logic [31:0] q[$];
  logic starve = 1'b0;
  int busy_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  int m_ph = 0, m_bp = 0;
  bit m_run = 0, m_sclk = 0, m_fs = 0, m_sd = 0, m_und = 0;
  logic [31:0] m_word = '0, m_mask = '0;
  int m_len = 1, m_w = 1, m_slots = 1, m_dsz = 1, m_ssz = 1, m_off = 0;
  bit m_low = 0, m_early = 0, m_lsb = 0, m_pol = 0;

  task automatic chk(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(output bit exp_ready);
    bit nrun, st_idle, need;
    int nbp, slot, p, k;
    exp_ready = 0;
    if (m_ph == PER - 1) begin
      st_idle = 0; nbp = 0;
      if (m_run && m_bp != m_len - 1) begin
        nrun = 1; nbp = m_bp + 1;
      end else if (en) begin
        nrun = 1; st_idle = !m_run;
        m_len = int'(c_len_m1) + 1; m_w = int'(c_sw_m1) + 1;
        m_low = c_low; m_early = c_early; m_slots = int'(c_slots_m1) + 1;
        m_dsz = int'(c_dsz_m1) + 1; m_off = int'(c_off); m_lsb = c_lsb;
        m_pol = c_pol; m_mask = c_mask;
        m_ssz = (c_code == 2'd1) ? 16 : (c_code == 2'd3) ? 32 : m_dsz;
      end else nrun = 0;
      if (nrun) begin
        slot = nbp / m_ssz; p = nbp % m_ssz;
        need = (p == 0) && (slot < m_slots) && !m_mask[slot];
        exp_ready = need;
        if (need && s_valid) begin
          m_word = s_data; void'(q.pop_front());
        end else if (p == 0) m_word = '0;
        if (need && !s_valid) m_und = 1;
        else if (st_idle) m_und = 0;
        if (p >= m_off && p - m_off < m_dsz) begin
          k = p - m_off;
          m_sd = m_lsb ? m_word[k] : m_word[m_dsz - 1 - k];
        end else m_sd = 0;
        m_fs = (m_early ? (nbp == m_len - 1 || nbp < m_w - 1) : (nbp < m_w)) ^ m_low;
        m_sclk = m_pol;
      end else begin
        m_sd = 0; m_fs = c_low; m_sclk = c_pol;
      end
      m_run = nrun; m_bp = nbp;
    end else if (m_ph == HALF - 1 && m_run) begin
      m_sclk = !m_pol;
    end
    m_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
  endtask

  always @(negedge clk) begin
    bit er;
    if (rst) begin
      m_ph = 0; m_run = 0; m_sclk = 0; m_fs = 0; m_sd = 0; m_und = 0; m_word = '0;
    end else begin
      chk(cur_req, "sclk", sclk, m_sclk);
      chk(cur_req, "fsync", fsync, m_fs);
      chk(cur_req, "sdata", sdata, m_sd);
      chk(cur_req, "busy", busy, m_run);
      chk("R11", "underflow", underflow, m_und);
      if (busy) busy_cnt++;
      s_valid = (q.size() > 0) && !starve;
      s_data  = (q.size() > 0) ? q[0] : '0;
      model_step(er);
      chk("R10", "s_ready", s_ready, er);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic set_cfg(int len_m1, int sw_m1, bit low, bit early, int slots_m1, int code,
                         int off, int dsz_m1, bit lsb, bit pol, logic [31:0] mask);
    c_len_m1 = 10'(len_m1); c_sw_m1 = 8'(sw_m1); c_low = low; c_early = early;
    c_slots_m1 = 5'(slots_m1); c_code = 2'(code); c_off = 5'(off);
    c_dsz_m1 = 5'(dsz_m1); c_lsb = lsb; c_pol = pol; c_mask = mask;
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      q.push_back(seed ^ {seed[15:0], seed[31:16]});
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stop_wait();
    en = 1'b0;
    for (int i = 0; i < 20000 && (busy || cyc < 0); i++) @(posedge clk);
    cycles(PER * 2);
  endtask

  initial begin
    set_cfg(31, 0, 0, 0, 1, 1, 0, 15, 0, 0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "sclk", sclk, 1'b0);
    chk("R1", "fsync", fsync, 1'b0);
    chk("R1", "sdata", sdata, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "underflow", underflow, 1'b0);
    chk("R1", "s_ready", s_ready, 1'b0);
    @(posedge clk); #1 rst = 1'b0;

    // R3 two 16-bit slots in a 32-bit frame, then the 8-bit minimum frame
    cur_req = "R3";
    push_n(12); en = 1'b1; cycles(32 * PER * 3);
    stop_wait();
    set_cfg(7, 0, 0, 0, 0, 0, 0, 7, 0, 0, '0);
    push_n(6); en = 1'b1; cycles(8 * PER * 4);
    stop_wait();

    // R2 inverted bit clock
    cur_req = "R2";
    set_cfg(31, 0, 0, 0, 1, 1, 0, 15, 0, 1, '0);
    push_n(8); en = 1'b1; cycles(32 * PER * 3);
    stop_wait();

    // R4 wide active-low sync
    cur_req = "R4";
    set_cfg(47, 4, 1, 0, 2, 1, 0, 15, 0, 0, '0);
    push_n(10); en = 1'b1; cycles(48 * PER * 3);
    stop_wait();

    // R5 early sync wrapping the frame boundary
    cur_req = "R5";
    set_cfg(31, 2, 0, 1, 1, 1, 0, 15, 0, 0, '0);
    push_n(10); en = 1'b1; cycles(32 * PER * 4);
    stop_wait();

    // R6 32-bit slots, then data-sized slots with spare bits at frame end
    cur_req = "R6";
    set_cfg(127, 0, 0, 0, 3, 3, 0, 23, 0, 0, '0);
    push_n(10); en = 1'b1; cycles(128 * PER * 2);
    stop_wait();
    set_cfg(99, 0, 0, 0, 2, 0, 0, 23, 0, 0, '0);
    push_n(8); en = 1'b1; cycles(100 * PER * 2);
    stop_wait();

    // R7 offset inside slot, and data field cut at slot end
    cur_req = "R7";
    set_cfg(63, 0, 0, 0, 3, 1, 3, 11, 0, 0, '0);
    push_n(10); en = 1'b1; cycles(64 * PER * 2);
    stop_wait();
    set_cfg(63, 0, 0, 0, 3, 1, 2, 19, 0, 0, '0);
    push_n(10); en = 1'b1; cycles(64 * PER * 2);
    stop_wait();

    // R8 LSB first
    cur_req = "R8";
    set_cfg(63, 0, 0, 0, 3, 1, 1, 13, 1, 0, '0);
    push_n(10); en = 1'b1; cycles(64 * PER * 2);
    stop_wait();

    // R9 masked slots take no samples
    cur_req = "R9";
    q.delete();
    set_cfg(63, 0, 0, 0, 3, 1, 0, 15, 0, 0, 32'h0000_0005);
    push_n(20); busy_cnt = 0; en = 1'b1; cycles(64 * PER * 2 + 20);
    stop_wait();
    chk_int("R9", "samples consumed", 20 - q.size(), 2 * (busy_cnt / (64 * PER)));

    // R10 stream with gaps
    cur_req = "R10";
    set_cfg(31, 0, 0, 0, 3, 0, 0, 7, 0, 0, '0);
    push_n(30); en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      starve = (i % 2 == 1);
      cycles(32 * PER / 2 + 3);
    end
    starve = 1'b0;
    stop_wait();

    // R11 underflow set, then cleared by a new start
    cur_req = "R11";
    q.delete();
    set_cfg(31, 0, 0, 0, 1, 1, 0, 15, 0, 0, '0);
    en = 1'b1; cycles(32 * PER);
    chk("R11", "underflow after empty slot", underflow, 1'b1);
    stop_wait();
    chk("R11", "underflow held while idle", underflow, 1'b1);
    push_n(8); en = 1'b1;
    for (int i = 0; i < 100 && !busy; i++) @(posedge clk);
    @(negedge clk);
    chk("R11", "underflow cleared at start", underflow, 1'b0);
    cycles(32 * PER);
    stop_wait();

    // R12 mid-frame reconfiguration
    cur_req = "R12";
    set_cfg(31, 0, 0, 0, 1, 1, 0, 15, 0, 0, '0);
    push_n(12); en = 1'b1; cycles(10 * PER);
    set_cfg(47, 1, 0, 0, 2, 1, 2, 11, 1, 0, '0);
    cycles(48 * PER * 2);
    stop_wait();

    // R13 enable drop completes the frame
    cur_req = "R13";
    set_cfg(63, 0, 0, 0, 3, 1, 0, 15, 0, 0, '0);
    push_n(8); busy_cnt = 0; en = 1'b1;
    for (int i = 0; i < 100 && !busy; i++) @(posedge clk);
    cycles(10);
    en = 1'b0;
    @(negedge clk);
    chk("R13", "busy after drop", busy, 1'b1);
    cycles(64 * PER + 4);
    @(negedge clk);
    chk("R13", "busy at end", busy, 1'b0);
    chk_int("R13", "busy cycles", busy_cnt, 64 * PER);
    chk("R13", "sdata idle", sdata, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule